// File: doc/BRIEF.md
# Priority-Masked Interrupt Controller

This block gathers interrupt requests from internal sources and from a small set of external pins, and holds each one in a pending flag. Each source has its own enable bit and a 3-bit priority. Every clock cycle the controller picks the most urgent source that is both pending and enabled. It compares that source's priority with the current processor priority level. When the source's priority is strictly higher, the controller raises a take signal and presents a vector address for that source.

On the clock edge that ends a take cycle, the controller loads the winning priority as the new processor level. This masks every request of equal or lower priority until software lowers the level again. The vector comes from one of two tables of identical layout: a default table and an alternate table placed directly after it. One select input chooses the table.

The external pins pass through edge detectors. Each detector triggers on a rising or a falling edge, chosen per pin. When the core reports sleep or idle, a take also raises a wake output in the same cycle, so the core resumes and enters the service routine in one step.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, all pending flags are 0, the current level is 0, and `irq_take` and `wake` are 0.
- R2: A high bit on `int_req` sets the matching pending flag at the next clock edge. The flag stays set until a 1 on the matching `flag_clr` bit clears it. When a set and a clear reach the same source in the same cycle, the set wins.
- R3: Each `ext_pol` bit selects the trigger edge of its external pin: 1 means rising, 0 means falling. A qualifying transition sets the flag at the next clock edge. A transition in the other direction has no effect. Pin i drives source i.
- R4: `irq_take` is high only if the winning source is pending, its `src_en` bit is set, and its priority is strictly greater than `cur_lvl`. A priority equal to the level does not interrupt.
- R5: Among sources that are pending and enabled, the one with the highest priority wins. When priorities are equal, the lower source index wins.
- R6: At the clock edge that ends a cycle with `irq_take` high, `cur_lvl` becomes the winner's priority. The take then drops while no higher-priority request is pending.
- R7: While `alt_tbl` is 0, `irq_vec` equals DEF_BASE + index. While `alt_tbl` is 1, it equals DEF_BASE + N_SRC + index.
- R8: A `lvl_wr` pulse loads `lvl_wdata` into `cur_lvl` at the next clock edge. A take in the same cycle has precedence.
- R9: `wake` is high exactly when `irq_take` is high and `core_sleep` or `core_idle` is high, in the same cycle.
- R10: The outputs `irq_take`, `irq_vec` and `wake` are combinational from the registered flags and level. They respond in the cycle after the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | N_EXT | External request pins, pin i feeds source i |
| ext_pol | input | N_EXT | Edge select per pin: 1 rising, 0 falling |
| int_req | input | N_SRC-N_EXT | Internal request pulses for sources N_EXT and above |
| src_en | input | N_SRC | Per-source enable |
| src_prio | input | 3*N_SRC | Per-source priority, source i in bits [3i+2:3i] |
| flag_clr | input | N_SRC | Write-one-to-clear for the pending flags |
| alt_tbl | input | 1 | Selects the alternate vector table |
| lvl_wr | input | 1 | Software write strobe for the current level |
| lvl_wdata | input | 3 | Level value to write |
| core_sleep | input | 1 | Core is in sleep |
| core_idle | input | 1 | Core is in idle |
| pending | output | N_SRC | Pending flags |
| cur_lvl | output | 3 | Current processor priority level |
| irq_take | output | 1 | Interrupt is taken this cycle |
| irq_vec | output | VEC_W | Vector address of the winner |
| irq_prio | output | 3 | Priority of the winner |
| wake | output | 1 | Wake request to a dormant core |

## Verification
A request or pin change applied in one cycle shows up in `pending` after the next rising edge. `irq_take`, `irq_vec` and `wake` follow in that same cycle, with no extra register between them. The level load appears one edge later, together with the drop of `irq_take`. Level writes take effect one edge after the strobe. The bench drives inputs on falling edges and samples after the next falling edge, so each result is read exactly one rising edge after its stimulus. It sweeps every source against every priority and every level.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int PRIO_W = 3;

    typedef logic [PRIO_W-1:0] prio_t;

    // edge qualifier: pol=1 rising, pol=0 falling
    function automatic logic edge_hit(input logic cur, input logic prev, input logic pol);
        return pol ? (cur & ~prev) : (~cur & prev);
    endfunction

endpackage

// File: rtl/intc_edge_det.sv
module intc_edge_det
    import intc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic pol_i,
    output logic hit_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin_i;
    end

    assign hit_o = edge_hit(pin_i, prev_q, pol_i);

endmodule

// File: rtl/intc_flag_bank.sv
module intc_flag_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] flags_o
);
    logic [N_SRC-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags_o = flags_q;

    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    // R2
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_i)) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_SRC-1:0]    req_i,
    input  logic [3*N_SRC-1:0]  prio_i,
    output logic                valid_o,
    output prio_t               prio_o,
    output logic [IDX_W-1:0]    idx_o
);
    always_comb begin
        valid_o = 1'b0;
        prio_o  = '0;
        idx_o   = '0;
        // ascending scan with strict compare keeps the lowest index on ties
        for (int i = 0; i < N_SRC; i++) begin
            if (req_i[i] && (!valid_o || prio_i[i*PRIO_W +: PRIO_W] > prio_o)) begin
                valid_o = 1'b1;
                prio_o  = prio_i[i*PRIO_W +: PRIO_W];
                idx_o   = IDX_W'(i);
            end
        end
    end

    // R5
    win_pending_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> req_i[idx_o]);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import intc_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int N_EXT = 5,
    parameter int VEC_W = 8,
    parameter logic [VEC_W-1:0] DEF_BASE = 8'd4,
    localparam int N_INT = N_SRC - N_EXT,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_EXT-1:0]     ext_pin,
    input  logic [N_EXT-1:0]     ext_pol,
    input  logic [N_INT-1:0]     int_req,
    input  logic [N_SRC-1:0]     src_en,
    input  logic [3*N_SRC-1:0]   src_prio,
    input  logic [N_SRC-1:0]     flag_clr,
    input  logic                 alt_tbl,
    input  logic                 lvl_wr,
    input  logic [2:0]           lvl_wdata,
    input  logic                 core_sleep,
    input  logic                 core_idle,
    output logic [N_SRC-1:0]     pending,
    output logic [2:0]           cur_lvl,
    output logic                 irq_take,
    output logic [VEC_W-1:0]     irq_vec,
    output logic [2:0]           irq_prio,
    output logic                 wake
);
    localparam logic [VEC_W-1:0] ALT_BASE = DEF_BASE + VEC_W'(N_SRC);

    logic [N_EXT-1:0] ext_hit;
    logic [N_SRC-1:0] set_vec;
    logic             win_valid;
    prio_t            win_prio;
    logic [IDX_W-1:0] win_idx;
    prio_t            lvl_q;

    generate
        for (genvar g = 0; g < N_EXT; g++) begin : g_edge
            intc_edge_det u_edge (
                .clk   (clk),
                .rst   (rst),
                .pin_i (ext_pin[g]),
                .pol_i (ext_pol[g]),
                .hit_o (ext_hit[g])
            );
        end
    endgenerate

    assign set_vec = {int_req, ext_hit};

    intc_flag_bank #(.N_SRC(N_SRC)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_vec),
        .clr_i   (flag_clr),
        .flags_o (pending)
    );

    intc_arbiter #(.N_SRC(N_SRC)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req_i   (pending & src_en),
        .prio_i  (src_prio),
        .valid_o (win_valid),
        .prio_o  (win_prio),
        .idx_o   (win_idx)
    );

    assign irq_take = win_valid && (win_prio > lvl_q);
    assign irq_prio = win_prio;
    assign irq_vec  = (alt_tbl ? ALT_BASE : DEF_BASE) + VEC_W'(win_idx);
    assign wake     = irq_take && (core_sleep || core_idle);
    assign cur_lvl  = lvl_q;

    always_ff @(posedge clk) begin
        if (rst)           lvl_q <= '0;
        else if (irq_take) lvl_q <= win_prio;
        else if (lvl_wr)   lvl_q <= lvl_wdata;
    end

    // R6
    lvl_load_chk: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> (cur_lvl == $past(irq_prio)));

    // R4
    take_above_chk: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> (|(pending & src_en)));

    // R9
    wake_take_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> irq_take);

    // R7
    vec_range_chk: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> (irq_vec >= DEF_BASE && irq_vec < ALT_BASE + VEC_W'(N_SRC)));

endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int NE = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic [NE-1:0] ext_pin;
    logic [NE-1:0] ext_pol;
    logic [NS-NE-1:0] int_req;
    logic [NS-1:0] src_en;
    logic [3*NS-1:0] src_prio;
    logic [NS-1:0] flag_clr;
    logic          alt_tbl;
    logic          lvl_wr;
    logic [2:0]    lvl_wdata;
    logic          core_sleep;
    logic          core_idle;
    logic [NS-1:0] pending;
    logic [2:0]    cur_lvl;
    logic          irq_take;
    logic [7:0]    irq_vec;
    logic [2:0]    irq_prio;
    logic          wake;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .ext_pol(ext_pol),
        .int_req(int_req), .src_en(src_en), .src_prio(src_prio),
        .flag_clr(flag_clr), .alt_tbl(alt_tbl), .lvl_wr(lvl_wr),
        .lvl_wdata(lvl_wdata), .core_sleep(core_sleep), .core_idle(core_idle),
        .pending(pending), .cur_lvl(cur_lvl), .irq_take(irq_take),
        .irq_vec(irq_vec), .irq_prio(irq_prio), .wake(wake)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic raise(input int s);
        if (s < NE) ext_pin[s] = 1'b1;
        else        int_req[s-NE] = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; ext_pin = '0; ext_pol = '1; int_req = '0; src_en = '1;
        src_prio = '0; flag_clr = '0; alt_tbl = 1'b0; lvl_wr = 1'b0;
        lvl_wdata = '0; core_sleep = 1'b0; core_idle = 1'b0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state
        chk("R1 pending", int'(pending), 0);
        chk("R1 level", int'(cur_lvl), 0);
        chk("R1 take", int'(irq_take), 0);
        chk("R1 wake", int'(wake), 0);

        // exhaustive sweep: source x priority x level
        for (int s = 0; s < NS; s++) begin
            for (int p = 1; p < 8; p++) begin
                for (int l = 0; l < 8; l++) begin
                    bit expt;
                    src_prio = '0;
                    src_prio[s*3 +: 3] = 3'(p);
                    alt_tbl = 1'((s + p) % 2);
                    core_sleep = 1'((l >> 0) & 1);
                    core_idle = 1'((l >> 1) & 1) & ~core_sleep;
                    lvl_wr = 1'b1; lvl_wdata = 3'(l);
                    cyc();
                    lvl_wr = 1'b0;
                    chk("R8 level write", int'(cur_lvl), l);
                    raise(s);
                    cyc();
                    int_req = '0;
                    chk("R2/R3 flag set", int'(pending[s]), 1);
                    expt = (p > l);
                    chk("R4 R10 take", int'(irq_take), int'(expt));
                    if (expt) begin
                        chk("R7 vector", int'(irq_vec), 4 + s + (alt_tbl ? NS : 0));
                        chk("R9 wake", int'(wake), (l % 4 != 0) ? 1 : 0);
                    end else begin
                        chk("R9 no wake", int'(wake), 0);
                    end
                    cyc();
                    chk("R6 level load", int'(cur_lvl), expt ? p : l);
                    chk("R6 take drop", int'(irq_take), 0);
                    if (s < NE) begin
                        ext_pin[s] = 1'b0;
                        cyc();
                        chk("R3 falling ignored, flag held", int'(pending), 1 << s);
                    end
                    flag_clr[s] = 1'b1;
                    cyc();
                    flag_clr = '0;
                    chk("R2 w1c", int'(pending), 0);
                end
            end
        end
        core_sleep = 1'b0; core_idle = 1'b0; alt_tbl = 1'b0;

        // R3 falling-edge polarity
        for (int s = 0; s < NE; s++) begin
            ext_pol[s] = 1'b0;
            ext_pin[s] = 1'b1;
            cyc();
            chk("R3 rising ignored on falling pol", int'(pending[s]), 0);
            ext_pin[s] = 1'b0;
            cyc();
            chk("R3 falling edge sets", int'(pending[s]), 1);
            flag_clr[s] = 1'b1;
            cyc();
            flag_clr = '0;
            ext_pol[s] = 1'b1;
        end

        // R4 disabled source never interrupts
        for (int s = 0; s < NS; s++) begin
            lvl_wr = 1'b1; lvl_wdata = 3'd0;
            src_prio = '0; src_prio[s*3 +: 3] = 3'd7;
            src_en = ~(NS'(1) << s);
            cyc();
            lvl_wr = 1'b0;
            raise(s);
            cyc();
            int_req = '0;
            chk("R4 disabled no take", int'(irq_take), 0);
            if (s < NE) ext_pin[s] = 1'b0;
            flag_clr = '1;
            cyc();
            flag_clr = '0;
        end
        src_en = '1;

        // R2 set beats clear in same cycle
        int_req[0] = 1'b1;
        cyc();
        int_req[0] = 1'b1; flag_clr[NE] = 1'b1;
        cyc();
        int_req = '0; flag_clr = '0;
        chk("R2 set wins over clear", int'(pending[NE]), 1);
        flag_clr = '1;
        cyc();
        flag_clr = '0;

        // R5 arbitration patterns
        for (int c = 0; c < 6; c++) begin
            int bp, bi;
            for (int i = 0; i < NS; i++)
                src_prio[i*3 +: 3] = (c >= 4) ? 3'(c - 1) : 3'((i * 3 + c * 5) % 8);
            src_en = 8'hFF ^ (8'(c) << 1);
            lvl_wr = 1'b1; lvl_wdata = 3'd0;
            cyc();
            lvl_wr = 1'b0;
            ext_pin = '1; int_req = '1;
            cyc();
            int_req = '0;
            bp = 0; bi = 0;
            for (int i = 0; i < NS; i++)
                if (src_en[i] && int'(src_prio[i*3 +: 3]) > bp) begin
                    bp = int'(src_prio[i*3 +: 3]); bi = i;
                end
            chk("R5 take", int'(irq_take), (bp > 0) ? 1 : 0);
            if (bp > 0) begin
                chk("R5 winner vector", int'(irq_vec), 4 + bi);
                chk("R5 winner prio", int'(irq_prio), bp);
            end
            ext_pin = '0;
            cyc();
            flag_clr = '1;
            cyc();
            flag_clr = '0;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule